// File: doc/BRIEF.md
# Prescaled Timer with Match Actions

This block is a free-running timer built from two counters: a prescale counter and a timer count. The prescale counter runs on every enabled tick. When it reaches the programmed prescale limit, the next enabled tick wraps it to zero and advances the timer count.

A bank of match channels compares its values against the timer count. Each channel has its own three actions, set by separate bits: raise an interrupt flag, return the count to zero, or halt both counters. A halt also drops the run bit in the control register.

A small register bus reads and writes every register. An input unit supplies two signals:
- `tick_i`, which qualifies counting. Tie it high to count every clock.
- `clr_i`, a clear pulse.

An output unit receives one match pulse per channel. A single interrupt request combines all pending match flags.

Top module: `ptmr_top`

## Requirements
- R1: While enabled ticks arrive, the prescale count (offset 0x10) increments by one per tick. A tick with the prescale count equal to the prescale limit (offset 0x0C) clears the prescale count and advances the timer count (offset 0x08). The timer count therefore advances once every limit+1 enabled ticks. A tick is enabled when control bit 0 is 1, control bit 1 is 0 and `tick_i` is 1.
- R2: Setting control bit 1 (offset 0x04) forces both counters to zero from the next clock on, and they stay at zero while the bit stays 1. A one-cycle `clr_i` pulse also zeroes both counters.
- R3: With `tick_i` low, neither counter moves, even while control bit 0 is 1.
- R4: The timer count, prescale count, prescale limit, match control (offset 0x14) and match values (offset 0x18 + 4·n) read back what was last written.
- R5: Match control bit 3n+2 is the halt action of channel n. When channel n hits with that bit set, both counters freeze at the matched value and control bit 0 reads back as 0.
- R6: Match control bit 3n+1 is the zero action of channel n. When the timer count equals match value n at the tick that would advance it, it loads 0 instead. The count period is then (match+1)·(limit+1) enabled ticks.
- R7: Match control bit 3n is the interrupt action of channel n. A hit on channel n sets flag bit n (offset 0x00) only when that bit is 1. With the bit at 0, the flag stays clear while `match_evt_o[n]` still pulses.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A hit in the same cycle as its clear leaves the flag set. Flag bits above the channel count always read 0.
- R9: A hit starts when the timer count takes a value equal to match value n. That value can come from an advance, a zero action, a bus write, or a clear from a nonzero value. `match_evt_o[n]` pulses for exactly one cycle, in the cycle after the count takes the value, and never repeats while the count stays frozen.
- R10: `irq_o` is high exactly when at least one flag bit is set.
- R11: After reset, all registers read 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count qualifier from the input unit |
| clr_i | input | 1 | Clear pulse for both counters |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| match_evt_o | output | 4 | One-cycle hit pulse per match channel |
| irq_o | output | 1 | Interrupt request, OR of pending flags |

## Verification
The hardest case to produce is a hit that lands in the same cycle as a write-1-to-clear of its own flag. The counters are halted for this test. The bench writes the timer count to the match value and, in the very next bus cycle, writes the clear. The write to the count fixes the exact cycle of the hit, so the clear lands on it.

The halt case needs similar care. Only a one-cycle event count over a long idle window shows that the frozen count does not hit again.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned ACTS_PER_CH = 3;
  localparam int unsigned ACT_IRQ     = 0;
  localparam int unsigned ACT_ZERO    = 1;
  localparam int unsigned ACT_HALT    = 2;

  localparam logic [7:0] OFS_FLAG = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_TC   = 8'h08;
  localparam logic [7:0] OFS_PR   = 8'h0C;
  localparam logic [7:0] OFS_PC   = 8'h10;
  localparam logic [7:0] OFS_MCTL = 8'h14;
  localparam logic [7:0] OFS_MR0  = 8'h18;

  function automatic logic [7:0] mr_ofs(int unsigned n);
    return OFS_MR0 + 8'(4 * n);
  endfunction
endpackage

// File: rtl/ptmr_count.sv
module ptmr_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tc_wr_i,
  input  logic             pc_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] pr_i,
  input  logic             zero_i,
  output logic [CNT_W-1:0] tc_o,
  output logic [CNT_W-1:0] pc_o,
  output logic             fresh_o
);
  logic [CNT_W-1:0] tc_q, pc_q;
  logic             fresh_q;
  logic             roll;

  assign roll = run_i && (pc_q == pr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q    <= '0;
      pc_q    <= '0;
      fresh_q <= 1'b0;
    end else if (clear_i) begin
      tc_q    <= '0;
      pc_q    <= '0;
      fresh_q <= (tc_q != '0);
    end else begin
      if (pc_wr_i)  pc_q <= wdata_i;
      else if (run_i) pc_q <= roll ? '0 : pc_q + CNT_W'(1);
      if (tc_wr_i)  tc_q <= wdata_i;
      else if (roll) tc_q <= zero_i ? '0 : tc_q + CNT_W'(1);
      fresh_q <= tc_wr_i || roll;
    end
  end

  assign tc_o    = tc_q;
  assign pc_o    = pc_q;
  assign fresh_o = fresh_q;
endmodule

// File: rtl/ptmr_match.sv
module ptmr_match import ptmr_pkg::*; #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned MCTL_W = ACTS_PER_CH * NUM_CH
) (
  input  logic [CNT_W-1:0]             tc_i,
  input  logic                         fresh_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] mr_i,
  input  logic [MCTL_W-1:0]            mctl_i,
  output logic [NUM_CH-1:0]            hit_o,
  output logic [NUM_CH-1:0]            flag_set_o,
  output logic                         zero_o,
  output logic                         halt_o
);
  logic [NUM_CH-1:0] eq, zero_ch, halt_ch;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign eq[n]         = (tc_i == mr_i[n]);
    assign hit_o[n]      = fresh_i && eq[n];
    assign flag_set_o[n] = hit_o[n] && mctl_i[ACTS_PER_CH*n + ACT_IRQ];
    assign zero_ch[n]    = eq[n] && mctl_i[ACTS_PER_CH*n + ACT_ZERO];
    assign halt_ch[n]    = hit_o[n] && mctl_i[ACTS_PER_CH*n + ACT_HALT];
  end

  assign zero_o = |zero_ch;
  assign halt_o = |halt_ch;
endmodule

// File: rtl/ptmr_flags.sv
module ptmr_flags #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic              clr_wr_i,
  input  logic [NUM_CH-1:0] clr_mask_i,
  output logic [NUM_CH-1:0] flags_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] flags_q;

  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~(clr_wr_i ? clr_mask_i : '0)) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |flags_q;
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top import ptmr_pkg::*; #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [7:0]        addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] match_evt_o,
  output logic              irq_o
);
  localparam int unsigned MCTL_W = ACTS_PER_CH * NUM_CH;

  logic                         cen_q, crst_q;
  logic [CNT_W-1:0]             pr_q;
  logic [MCTL_W-1:0]            mctl_q;
  logic [NUM_CH-1:0][CNT_W-1:0] mr_q;
  logic [CNT_W-1:0]             tc_val, pc_val;
  logic                         fresh, zero_hit, halt_hit, run, clear;
  logic [NUM_CH-1:0]            hit, flag_set, flags;
  logic                         wr_flag, wr_ctrl, wr_tc, wr_pr, wr_pc, wr_mctl;

  assign wr_flag = wr_i && (addr_i == OFS_FLAG);
  assign wr_ctrl = wr_i && (addr_i == OFS_CTRL);
  assign wr_tc   = wr_i && (addr_i == OFS_TC);
  assign wr_pr   = wr_i && (addr_i == OFS_PR);
  assign wr_pc   = wr_i && (addr_i == OFS_PC);
  assign wr_mctl = wr_i && (addr_i == OFS_MCTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q  <= 1'b0;
      crst_q <= 1'b0;
      pr_q   <= '0;
      mctl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        cen_q  <= wdata_i[0];
        crst_q <= wdata_i[1];
      end
      if (halt_hit) cen_q <= 1'b0;
      if (wr_pr)   pr_q   <= wdata_i;
      if (wr_mctl) mctl_q <= wdata_i[MCTL_W-1:0];
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_mr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mr_q[n] <= '0;
      else if (wr_i && (addr_i == mr_ofs(n)))     mr_q[n] <= wdata_i;
    end
  end

  assign run   = cen_q && !crst_q && tick_i && !halt_hit;
  assign clear = crst_q || clr_i;

  ptmr_count #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .run_i   (run),
    .tc_wr_i (wr_tc),
    .pc_wr_i (wr_pc),
    .wdata_i (wdata_i),
    .pr_i    (pr_q),
    .zero_i  (zero_hit),
    .tc_o    (tc_val),
    .pc_o    (pc_val),
    .fresh_o (fresh)
  );

  ptmr_match #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_match (
    .tc_i       (tc_val),
    .fresh_i    (fresh),
    .mr_i       (mr_q),
    .mctl_i     (mctl_q),
    .hit_o      (hit),
    .flag_set_o (flag_set),
    .zero_o     (zero_hit),
    .halt_o     (halt_hit)
  );

  ptmr_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (flag_set),
    .clr_wr_i   (wr_flag),
    .clr_mask_i (wdata_i[NUM_CH-1:0]),
    .flags_o    (flags),
    .irq_o      (irq_o)
  );

  assign match_evt_o = hit;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_FLAG: rdata_o = CNT_W'(flags);
      OFS_CTRL: rdata_o = CNT_W'({crst_q, cen_q});
      OFS_TC:   rdata_o = tc_val;
      OFS_PR:   rdata_o = pr_q;
      OFS_PC:   rdata_o = pc_val;
      OFS_MCTL: rdata_o = CNT_W'(mctl_q);
      default:  ;
    endcase
    for (int n = 0; n < NUM_CH; n++)
      if (addr_i == mr_ofs(n)) rdata_o = mr_q[n];
  end
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk import ptmr_pkg::*; #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              clr_i,
  input logic              wr_i,
  input logic [7:0]        addr_i,
  input logic              cen_q,
  input logic              crst_q,
  input logic [CNT_W-1:0]  pr_q,
  input logic [CNT_W-1:0]  tc_val,
  input logic [CNT_W-1:0]  pc_val,
  input logic              halt_hit,
  input logic [NUM_CH-1:0] flag_set,
  input logic [NUM_CH-1:0] flags,
  input logic              irq_o
);
  logic pc_wr, tc_wr;
  assign pc_wr = wr_i && (addr_i == OFS_PC);
  assign tc_wr = wr_i && (addr_i == OFS_TC);

  p_prescale_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_q && !crst_q && tick_i && !halt_hit && !clr_i && !pc_wr && pc_val != pr_q)
    |=> pc_val == $past(pc_val) + CNT_W'(1));

  p_crst_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crst_q |=> (tc_val == '0 && pc_val == '0));

  p_halt_disable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_hit |=> !cen_q);

  p_halt_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_hit && !crst_q && !clr_i && !tc_wr) |=> $stable(tc_val));

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set)));

  p_irq_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(flag_set) != '0));
endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .clr_i    (clr_i),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .cen_q    (cen_q),
  .crst_q   (crst_q),
  .pr_q     (pr_q),
  .tc_val   (tc_val),
  .pc_val   (pc_val),
  .halt_hit (halt_hit),
  .flag_set (flag_set),
  .flags    (flags),
  .irq_o    (irq_o)
);

// File: tb/tb_ptmr_top.sv
`timescale 1ns/1ps
module tb_ptmr_top;
  localparam logic [7:0] A_FLAG = 8'h00, A_CTRL = 8'h04, A_TC = 8'h08,
                         A_PR = 8'h0C, A_PC = 8'h10, A_MCTL = 8'h14;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, clr_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  match_evt_o;
  logic        irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ptmr_top dut (.*);

  function automatic logic [7:0] a_mr(int n);
    return 8'h18 + 8'(4 * n);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    addr_i = a; #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); @(negedge clk_i);
    end
  endtask

  task automatic t_reset_state;
    rd_chk("R11 flags", A_FLAG, 0);
    rd_chk("R11 ctrl", A_CTRL, 0);
    rd_chk("R11 tc", A_TC, 0);
    rd_chk("R11 pr", A_PR, 0);
    rd_chk("R11 pc", A_PC, 0);
    rd_chk("R11 mctl", A_MCTL, 0);
    for (int n = 0; n < 4; n++) rd_chk("R11 match", a_mr(n), 0);
    chk("R11 irq", 32'(irq_o), 0);
  endtask

  task automatic t_prescale;
    tick_i = 1'b1;
    bus_wr(A_PR, 2);
    bus_wr(A_CTRL, 1);
    idle(8);
    bus_wr(A_CTRL, 0);          // 9 enabled ticks
    rd_chk("R1 tc after 9 ticks", A_TC, 3);
    rd_chk("R1 pc after 9 ticks", A_PC, 0);
    bus_wr(A_CTRL, 1);
    idle(3);
    bus_wr(A_CTRL, 0);          // 4 more ticks
    rd_chk("R1 tc after 13 ticks", A_TC, 4);
    rd_chk("R1 pc after 13 ticks", A_PC, 1);
  endtask

  task automatic t_tick_gate;
    tick_i = 1'b0;
    bus_wr(A_CTRL, 1);
    idle(5);
    bus_wr(A_CTRL, 0);
    rd_chk("R3 tc held", A_TC, 4);
    rd_chk("R3 pc held", A_PC, 1);
    tick_i = 1'b1;
  endtask

  task automatic t_counter_reset;
    bus_wr(A_CTRL, 3);
    idle(4);
    rd_chk("R2 tc zero", A_TC, 0);
    rd_chk("R2 pc zero", A_PC, 0);
    bus_wr(A_CTRL, 1);
    idle(2);
    bus_wr(A_CTRL, 0);          // 3 ticks after reset released
    rd_chk("R2 counting resumes", A_TC, 1);
    bus_wr(A_TC, 50);
    clr_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    clr_i = 1'b0;
    rd_chk("R2 clr pulse", A_TC, 0);
  endtask

  task automatic t_access;
    bus_wr(A_TC, 32'h1234_5678);
    rd_chk("R4 tc rw", A_TC, 32'h1234_5678);
    bus_wr(A_PC, 7);
    rd_chk("R4 pc rw", A_PC, 7);
    rd_chk("R4 pr rw", A_PR, 2);
    bus_wr(a_mr(3), 32'hCAFE_0001);
    rd_chk("R4 match3 rw", a_mr(3), 32'hCAFE_0001);
    bus_wr(A_MCTL, 32'h0000_0ABC);
    rd_chk("R4 mctl rw", A_MCTL, 32'h0000_0ABC);
    bus_wr(A_MCTL, 0);
    bus_wr(A_TC, 0);
    bus_wr(A_PC, 0);
  endtask

  task automatic t_zero_period;
    int first = -1, second = -1;
    bus_wr(A_PR, 1);
    bus_wr(a_mr(0), 3);
    bus_wr(A_MCTL, 32'h3);      // ch0 interrupt + zero
    bus_wr(A_FLAG, 32'hF);
    bus_wr(A_CTRL, 1);
    for (int c = 0; c < 40; c++) begin
      if (match_evt_o[0]) begin
        if (first < 0) first = c;
        else if (second < 0) second = c;
      end
      @(posedge clk_i); @(negedge clk_i);
    end
    bus_wr(A_CTRL, 0);
    chk("R6 period cycles", 32'(second - first), 8);
    rd_chk("R7 flag0 set", A_FLAG, 1);
    chk("R10 irq high", 32'(irq_o), 1);
    bus_wr(A_FLAG, 0);
    rd_chk("R8 write 0 keeps flag", A_FLAG, 1);
    bus_wr(A_FLAG, 1);
    rd_chk("R8 write 1 clears", A_FLAG, 0);
    chk("R10 irq low", 32'(irq_o), 0);
  endtask

  task automatic t_halt;
    int pulses = 0;
    bus_wr(A_PR, 0);
    bus_wr(A_TC, 0);
    bus_wr(A_PC, 0);
    bus_wr(a_mr(1), 5);
    bus_wr(A_MCTL, 32'h28);     // ch1 interrupt + halt
    bus_wr(A_FLAG, 32'hF);
    bus_wr(A_CTRL, 1);
    for (int c = 0; c < 24; c++) begin
      if (match_evt_o[1]) pulses++;
      @(posedge clk_i); @(negedge clk_i);
    end
    chk("R9 single pulse while halted", 32'(pulses), 1);
    rd_chk("R5 tc frozen", A_TC, 5);
    rd_chk("R5 run bit cleared", A_CTRL, 0);
    rd_chk("R7 flag1 set", A_FLAG, 2);
    bus_wr(A_FLAG, 32'hF);
  endtask

  task automatic t_no_irq_action;
    bus_wr(A_MCTL, 0);
    bus_wr(a_mr(2), 9);
    bus_wr(A_TC, 9);
    chk("R9 pulse after tc write", 32'(match_evt_o[2]), 1);
    idle(1);
    chk("R9 pulse one cycle", 32'(match_evt_o[2]), 0);
    rd_chk("R7 flag2 stays clear", A_FLAG, 0);
  endtask

  task automatic t_set_clear_race;
    bus_wr(A_MCTL, 32'h200);    // ch3 interrupt
    bus_wr(a_mr(3), 77);
    bus_wr(A_TC, 77);
    bus_wr(A_FLAG, 8);          // lands on the hit cycle
    rd_chk("R8 set wins over clear", A_FLAG, 8);
    bus_wr(A_FLAG, 8);
    rd_chk("R8 clear after race", A_FLAG, 0);
    bus_wr(A_FLAG, 32'h7F);
    rd_chk("R8 upper flag bits zero", A_FLAG, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset_state();
    t_prescale();
    t_tick_gate();
    t_counter_reset();
    t_access();
    t_zero_period();
    t_halt();
    t_no_irq_action();
    t_set_clear_race();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule